// File: doc/BRIEF.md
# Handshake-Ring FIFO Model

This block is a clock-stepped model of a self-timed first-in first-out ring. A chain of stages is closed into a loop. Each stage has one control bit and one data register. On every enabled clock tick, every control bit is re-evaluated as a two-input Muller C-element. The first input is the control bit of the stage before it. The second input is the inverted control bit of the stage after it. A stage's register copies its predecessor's data whenever that stage's control bit flips, on either edge (two-phase signalling). All stages update together from the values of the previous tick, so the order of evaluation cannot change the result.

Reset places a fixed control pattern and a set of data items in the ring. The data items alternate between all ones and all zeros. Every second stage holds an item, so the ring is half full, and the pattern is chosen so that the ring oscillates from the first tick. The items then travel round the loop one stage per tick and are never lost or duplicated. The stage count must be a multiple of four, and elaboration rejects any other value. The ring is meant to be watched through its control vector, its register contents and a tap on stage 0. A step enable freezes the whole ring while it is low.

Top module: `mpr_ring`

## Requirements
- R1: While reset is asserted, control bit i equals bit 1 of the index i. Register i is all ones when that bit is 1 and all zeros when it is 0.
- R2: On an enabled tick, a control bit takes the value of its predecessor's control bit if the predecessor's bit differs from the successor's bit. Otherwise it keeps its value. All stages use the previous tick's values.
- R3: A register loads its predecessor's previous contents exactly on the ticks when its own control bit flips, in either direction. On all other ticks it holds.
- R4: On every enabled tick exactly half of the control bits flip, and no two adjacent stages flip on the same tick. The ring never skips a tick and no stage runs more than one transition ahead of its neighbour.
- R5: A stage is occupied when its control bit differs from its predecessor's. Exactly UNITS/2 stages are occupied at all times, and no two adjacent stages are occupied together.
- R6: The stage 0 tap changes only when stage 0's control flips, and each change inverts it. After reset the tap reads zeros, then ones for two enabled ticks, then zeros for two ticks, and so on.
- R7: While the step enable is low, no control bit and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_en | input | 1 | Advance the ring by one tick on this clock edge |
| ctrl_o | output | UNITS | Control bit of every stage, bit i for stage i |
| data_o | output | UNITS*WIDTH | Register contents, stage i at bits [i*WIDTH +: WIDTH] |
| tap0_o | output | WIDTH | Register contents of stage 0 |

## Verification
The bench checks the wrap-around link between the last stage and stage 0. A wrong index there would freeze the ring or let an item be copied into two places, and the occupancy count and the stage 0 tap would show it. Stall runs of different lengths check that a disabled tick leaves everything unchanged. If a stage used neighbour values it had already updated in the same tick, adjacent stages would flip together and the flip count would no longer be half. A reset asserted in the middle of a run checks that the seed pattern returns at once and that the ring starts again in its first phase.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

  // Seed value for stage idx: pairs of stages alternate 0,0,1,1,...
  function automatic logic seed_bit(input int unsigned idx);
    return ((idx >> 1) % 2) == 1;
  endfunction

endpackage

// File: rtl/mpr_rst_sync.sv
module mpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mpr_ctrl_cell.sv
module mpr_ctrl_cell #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pred_i,
  input  logic succ_i,
  output logic q_o,
  output logic flip_o
);
  logic q_r;
  logic q_nxt;
  logic agree;

  // Muller C-element on (pred, ~succ): both equal -> follow, else hold
  always_comb begin
    agree = (pred_i != succ_i);
    q_nxt = agree ? pred_i : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= INIT;
    else if (en) q_r <= q_nxt;
  end

  assign q_o    = q_r;
  assign flip_o = en & (q_nxt != q_r);

  assert_c_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (pred_i != succ_i)) |=> (q_o == $past(pred_i)));

  assert_c_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (pred_i == succ_i)) |=> $stable(q_o));

  assert_ctrl_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q_o));
endmodule

// File: rtl/mpr_data_cell.sv
module mpr_data_cell #(
  parameter int unsigned W    = 8,
  parameter logic        INIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = load_i ? d_i : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= {W{INIT}};
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

  assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_o == $past(d_i)));

  assert_load_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/mpr_ring.sv
module mpr_ring #(
  parameter int unsigned UNITS = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_en,
  output logic [UNITS-1:0]         ctrl_o,
  output logic [UNITS*WIDTH-1:0]   data_o,
  output logic [WIDTH-1:0]         tap0_o
);
  localparam int unsigned HALF = UNITS / 2;

  if ((UNITS < 4) || ((UNITS % 4) != 0)) begin : g_bad_units
    $error("mpr_ring: UNITS must be a nonzero multiple of four");
  end

  logic             rst_int;
  logic [UNITS-1:0] ctrl;
  logic [UNITS-1:0] flip;
  logic [WIDTH-1:0] stage_q [UNITS];
  logic [UNITS-1:0] occ;

  mpr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int)
  );

  for (genvar i = 0; i < UNITS; i++) begin : g_unit
    localparam int unsigned PRV = (i + UNITS - 1) % UNITS;
    localparam int unsigned SUC = (i + 1) % UNITS;

    mpr_ctrl_cell #(.INIT(mpr_pkg::seed_bit(i))) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_int),
      .en     (step_en),
      .pred_i (ctrl[PRV]),
      .succ_i (ctrl[SUC]),
      .q_o    (ctrl[i]),
      .flip_o (flip[i])
    );

    mpr_data_cell #(.W(WIDTH), .INIT(mpr_pkg::seed_bit(i))) u_data (
      .clk    (clk),
      .rst_n  (rst_int),
      .load_i (flip[i]),
      .d_i    (stage_q[PRV]),
      .q_o    (stage_q[i])
    );

    assign data_o[i*WIDTH +: WIDTH] = stage_q[i];
  end

  assign ctrl_o = ctrl;
  assign tap0_o = stage_q[0];

  // stage i holds an item when its control differs from its predecessor's
  assign occ = ctrl ^ {ctrl[UNITS-2:0], ctrl[UNITS-1]};

  assert_occupancy_R5: assert property (@(posedge clk) disable iff (!rst_int)
    ($countones(occ) == HALF) && ((occ & {occ[UNITS-2:0], occ[UNITS-1]}) == '0));

  assert_flip_half_R4: assert property (@(posedge clk) disable iff (!rst_int)
    step_en |-> ($countones(flip) == HALF) &&
                ((flip & {flip[UNITS-2:0], flip[UNITS-1]}) == '0));

  assert_tap_invert_R6: assert property (@(posedge clk) disable iff (!rst_int)
    flip[0] |=> (tap0_o == ~$past(tap0_o)));

  assert_tap_idle_R6: assert property (@(posedge clk) disable iff (!rst_int)
    !flip[0] |=> $stable(tap0_o));
endmodule

// File: tb/mpr_ring_test.sv
`timescale 1ns/1ps
module mpr_ring_test;
  localparam int NU = 8;
  localparam int DW = 8;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               step_en;
  logic [NU-1:0]      ctrl_o;
  logic [NU*DW-1:0]   data_o;
  logic [DW-1:0]      tap0_o;

  int checks = 0;
  int fails  = 0;
  bit exp_q[$];
  logic [NU-1:0] prev_ctrl;

  always #4 clk = ~clk;

  mpr_ring #(.UNITS(NU), .WIDTH(DW)) uut (
    .clk (clk), .rst_n (rst_n), .step_en (step_en),
    .ctrl_o (ctrl_o), .data_o (data_o), .tap0_o (tap0_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [NU*DW-1:0] act, input logic [NU*DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic seed_model();
    exp_q.delete();
    for (int i = 0; i < NU; i++) exp_q.push_back(((i / 2) % 2) == 1);
  endtask

  function automatic logic [NU-1:0] exp_ctrl();
    logic [NU-1:0] v;
    for (int i = 0; i < NU; i++) v[i] = exp_q[i];
    return v;
  endfunction

  function automatic logic [NU*DW-1:0] exp_data();
    logic [NU*DW-1:0] v;
    for (int i = 0; i < NU; i++) v[i*DW +: DW] = exp_q[i] ? '1 : '0;
    return v;
  endfunction

  task automatic check_all(input bit stepped);
    int occ_n, adj, chg;
    chk(ctrl_o == exp_ctrl(), "R2", "control vector", ctrl_o, exp_ctrl());
    chk(data_o == exp_data(), "R3", "register contents", data_o, exp_data());
    chk(tap0_o == (exp_q[0] ? {DW{1'b1}} : {DW{1'b0}}), "R6", "stage 0 tap",
        tap0_o, exp_q[0] ? {DW{1'b1}} : {DW{1'b0}});
    occ_n = 0; adj = 0;
    for (int i = 0; i < NU; i++) begin
      bit oi, on;
      oi = ctrl_o[i] != ctrl_o[(i + NU - 1) % NU];
      on = ctrl_o[(i + 1) % NU] != ctrl_o[i];
      if (oi) occ_n++;
      if (oi && on) adj++;
    end
    chk(occ_n == NU / 2 && adj == 0, "R5", "occupancy count/adjacency",
        occ_n * 256 + adj, (NU / 2) * 256);
    chg = $countones(ctrl_o ^ prev_ctrl);
    if (stepped) chk(chg == NU / 2, "R4", "flips per tick", chg, NU / 2);
    else         chk(chg == 0 && data_o == exp_data(), "R7", "stall changed state", chg, 0);
    prev_ctrl = ctrl_o;
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic cyc(input bit en);
    step_en = en;
    @(posedge clk);
    if (en) exp_q.push_front(exp_q.pop_back());
    @(negedge clk);
    check_all(en);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step_en = 1'b0;
    #1;
    seed_model();
    chk(ctrl_o == exp_ctrl(), "R1", "reset control", ctrl_o, exp_ctrl());
    chk(data_o == exp_data(), "R1", "reset data", data_o, exp_data());
    prev_ctrl = ctrl_o;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) cyc(1'b0);
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    step_en = 1'b0;
    @(negedge clk);
    do_reset();
    // R6: explicit tap sequence 1,1,0,0 after reset
    cyc(1'b1); chk(tap0_o == '1, "R6", "tap after tick 1", tap0_o, {DW{1'b1}});
    cyc(1'b1); chk(tap0_o == '1, "R6", "tap after tick 2", tap0_o, {DW{1'b1}});
    cyc(1'b1); chk(tap0_o == '0, "R6", "tap after tick 3", tap0_o, '0);
    cyc(1'b1); chk(tap0_o == '0, "R6", "tap after tick 4", tap0_o, '0);
    // continuous run over several trips round the ring (R2, R3, R4, R5)
    for (int k = 0; k < 60; k++) cyc(1'b1);
    // intermittent stepping with stalls of differing length (R7)
    for (int k = 0; k < 90; k++) cyc((k % 3) != 0 && (k % 7) != 5);
    for (int k = 0; k < 6; k++) cyc(1'b0);
    // reset in mid run, then restart in the first phase (R1)
    for (int k = 0; k < 5; k++) cyc(1'b1);
    do_reset();
    cyc(1'b1); chk(tap0_o == '1, "R6", "tap after restart", tap0_o, {DW{1'b1}});
    for (int k = 0; k < 40; k++) cyc(k % 2 == 0);
    for (int k = 0; k < 30; k++) cyc(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule